// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Timer

This block produces the write-enable and read-enable strobes for single asynchronous NAND bus cycles: command, address or data byte writes, and data byte reads. Every phase of a cycle is timed in clock ticks. The tick counts come from two packed 32-bit timing words that are applied at run time, so one instance can drive parts with different speed grades without being rebuilt.

A request port starts one cycle. A write carries a data byte, which is driven onto the bus. A read samples the bus at the end of the read-enable low phase and returns that byte together with a one-cycle completion pulse. A device-ready input gates both the acceptance of new requests and the completion of the current one. A helper function in the package converts picosecond durations into ticks, and it always rounds up.

Top module: `nand_strobe_timer`

## Requirements
- R1: Timing word layout. In `cfg_wr_timing`, [31:24] is the setup count, [23:16] the write-extend count, [15:8] the write cycle count and [7:0] the write-low count. In `cfg_rd_timing`, [31:24] is the read access count, [23:16] the read hold count, [15:8] the read-low count and [7:0] the bus release count.
- R2: A field value of 0 acts as 1 tick, so no phase lasts less than one clock cycle. Below, eff(x) is max(x,1).
- R3: A request is accepted on a clock edge only when the block is idle, `req_valid` is 1 and `dev_ready` is 1. `busy` is 1 from the next cycle until completion. Requests that arrive while busy are ignored, and so are changes to `req_data` while busy.
- R4: A write (`req_write`=1) runs eff(setup) cycles with both strobes high. Next, `nand_we_n` is low for eff(wlow) cycles. It is then high for eff(wcyc)-eff(wlow) cycles, or for 1 cycle if that difference is not positive. After that come eff(wext) extend cycles. `nand_dq_oe` is 1 with the accepted byte on `nand_dq_out` from setup through the write-high phase.
- R5: A read (`req_write`=0) runs eff(setup) cycles, then holds `nand_re_n` low for max(eff(racc), eff(rlow)) cycles. `nand_dq_in` is captured on the clock edge that ends the low phase. Then come eff(rhold) cycles with `nand_re_n` high and eff(rrel) bus release cycles.
- R6: After the last phase a wait stage of at least one cycle ends on the first edge at which `dev_ready` is 1. `done` is then 1 for exactly the first idle cycle. `rd_data` holds the last captured read byte, and writes leave it unchanged.
- R7: `nand_we_n` and `nand_re_n` are never low together, both are high while idle, and `nand_dq_oe` is 0 during reads.
- R8: After reset, `busy`, `done` and `nand_dq_oe` are 0, both strobes are 1, and `rd_data` is 0.
- R9: `nst_pkg::ticks_from_ps(khz, ps)` returns ceil(khz*ps / 10^9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_timing | input | 32 | Setup / write-extend / write cycle / write-low tick counts |
| cfg_rd_timing | input | 32 | Access / hold / read-low / release tick counts |
| req_valid | input | 1 | Request a bus cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_data | input | 8 | Byte to write |
| dev_ready | input | 1 | Device ready flag |
| nand_dq_in | input | 8 | Bus data in |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| nand_we_n | output | 1 | Write-enable strobe, active low |
| nand_re_n | output | 1 | Read-enable strobe, active low |
| nand_dq_out | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |

## Verification
The assertions assume that the timing words stay stable while `busy` is high and that `dev_ready` is driven to a known value on every cycle. The stimulus changes the timing words only between cycles, when the block is idle, and it drives `dev_ready` from the falling clock edge. The sweeps cover every field value from 0 to 3 for the strobe fields, with zero and non-zero extend, setup and release counts. The bench holds `dev_ready` low both before a request and during a cycle, and it keeps `req_valid` asserted with changed data while the block is busy.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int NST_TICK_W = 8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SETUP, PH_WLOW, PH_WHIGH, PH_WEXT,
    PH_RLOW, PH_RHOLD, PH_RREL, PH_WAIT
  } nst_phase_e;

  typedef struct packed {
    logic [NST_TICK_W-1:0] setup;
    logic [NST_TICK_W-1:0] wext;
    logic [NST_TICK_W-1:0] wcyc;
    logic [NST_TICK_W-1:0] wlow;
    logic [NST_TICK_W-1:0] racc;
    logic [NST_TICK_W-1:0] rhold;
    logic [NST_TICK_W-1:0] rlow;
    logic [NST_TICK_W-1:0] rrel;
  } nst_timing_t;

  // zero counts are raised to one tick
  function automatic logic [NST_TICK_W-1:0] eff_ticks(input logic [NST_TICK_W-1:0] f);
    return (f == '0) ? NST_TICK_W'(1) : f;
  endfunction

  // write-enable high time: rest of the write cycle, at least one tick
  function automatic logic [NST_TICK_W-1:0] wr_high_ticks(input logic [NST_TICK_W-1:0] cyc,
                                                          input logic [NST_TICK_W-1:0] low);
    logic [NST_TICK_W-1:0] a, b;
    a = eff_ticks(cyc);
    b = eff_ticks(low);
    return (a > b) ? (a - b) : NST_TICK_W'(1);
  endfunction

  // read-enable low time covers both access and pulse width
  function automatic logic [NST_TICK_W-1:0] rd_low_ticks(input logic [NST_TICK_W-1:0] acc,
                                                         input logic [NST_TICK_W-1:0] low);
    logic [NST_TICK_W-1:0] a, b;
    a = eff_ticks(acc);
    b = eff_ticks(low);
    return (a > b) ? a : b;
  endfunction

  // picoseconds to ticks at a clock in kHz, rounded up
  function automatic logic [63:0] ticks_from_ps(input logic [63:0] khz, input logic [63:0] ps);
    logic [63:0] prod;
    prod = khz * ps;
    return (prod + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction
endpackage

// File: rtl/nst_timing_unpack.sv
module nst_timing_unpack
  import nst_pkg::*;
#(
  parameter int TICK_W = NST_TICK_W
) (
  input  logic [4*TICK_W-1:0] wr_word,
  input  logic [4*TICK_W-1:0] rd_word,
  output nst_timing_t         timing
);
  localparam int FIELDS = 4;
  localparam int WORD_W = FIELDS * TICK_W;

  logic [TICK_W-1:0] wf [FIELDS];
  logic [TICK_W-1:0] rf [FIELDS];

  // field 0 is the most significant byte
  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    assign wf[g] = wr_word[WORD_W-1-g*TICK_W -: TICK_W];
    assign rf[g] = rd_word[WORD_W-1-g*TICK_W -: TICK_W];
  end

  assign timing.setup = wf[0];
  assign timing.wext  = wf[1];
  assign timing.wcyc  = wf[2];
  assign timing.wlow  = wf[3];
  assign timing.racc  = rf[0];
  assign timing.rhold = rf[1];
  assign timing.rlow  = rf[2];
  assign timing.rrel  = rf[3];
endmodule

// File: rtl/nst_phase_counter.sv
module nst_phase_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_ticks,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  // a phase of N ticks loads N-1 and expires when zero is reached
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_ticks - CNT_W'(1);
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/nst_cycle_fsm.sv
module nst_cycle_fsm
  import nst_pkg::*;
#(
  parameter int TICK_W = NST_TICK_W,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nst_timing_t       timing,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_data,
  input  logic              dev_ready,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              phase_end,
  output logic              load,
  output logic [TICK_W-1:0] load_ticks,
  output logic              accept,
  output logic              sample_evt,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              we_n,
  output logic              re_n
);
  nst_phase_e state, nxt;
  logic       is_wr, wr_nxt;

  assign accept     = (state == PH_IDLE) && req_valid && dev_ready;
  assign sample_evt = (state == PH_RLOW) && phase_end;
  assign wr_nxt     = accept ? req_write : is_wr;
  assign busy       = (state != PH_IDLE);

  always_comb begin
    nxt        = state;
    load       = 1'b0;
    load_ticks = TICK_W'(1);
    unique case (state)
      PH_IDLE: if (accept) begin
        nxt = PH_SETUP; load = 1'b1; load_ticks = eff_ticks(timing.setup);
      end
      PH_SETUP: if (phase_end) begin
        load = 1'b1;
        if (is_wr) begin
          nxt = PH_WLOW; load_ticks = eff_ticks(timing.wlow);
        end else begin
          nxt = PH_RLOW; load_ticks = rd_low_ticks(timing.racc, timing.rlow);
        end
      end
      PH_WLOW: if (phase_end) begin
        nxt = PH_WHIGH; load = 1'b1; load_ticks = wr_high_ticks(timing.wcyc, timing.wlow);
      end
      PH_WHIGH: if (phase_end) begin
        nxt = PH_WEXT; load = 1'b1; load_ticks = eff_ticks(timing.wext);
      end
      PH_WEXT: if (phase_end) nxt = PH_WAIT;
      PH_RLOW: if (phase_end) begin
        nxt = PH_RHOLD; load = 1'b1; load_ticks = eff_ticks(timing.rhold);
      end
      PH_RHOLD: if (phase_end) begin
        nxt = PH_RREL; load = 1'b1; load_ticks = eff_ticks(timing.rrel);
      end
      PH_RREL: if (phase_end) nxt = PH_WAIT;
      PH_WAIT: if (dev_ready) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  // strobes and enable are registered from the next phase: no decode glitches at the pads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      is_wr   <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
    end else begin
      state <= nxt;
      is_wr <= wr_nxt;
      done  <= (state == PH_WAIT) && dev_ready;
      if (accept)     dq_out  <= req_data;
      if (sample_evt) rd_data <= dq_in;
      we_n  <= (nxt != PH_WLOW);
      re_n  <= (nxt != PH_RLOW);
      dq_oe <= wr_nxt && ((nxt == PH_SETUP) || (nxt == PH_WLOW) || (nxt == PH_WHIGH));
    end
  end
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nst_pkg::*;
#(
  parameter int TICK_W = NST_TICK_W,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4*TICK_W-1:0] cfg_wr_timing,
  input  logic [4*TICK_W-1:0] cfg_rd_timing,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                dev_ready,
  input  logic [DATA_W-1:0]   nand_dq_in,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic [DATA_W-1:0]   nand_dq_out,
  output logic                nand_dq_oe
);
  nst_timing_t       timing;
  logic              load;
  logic [TICK_W-1:0] load_ticks;
  logic              phase_end;
  logic              accept;
  logic              sample_evt;

  nst_timing_unpack #(.TICK_W(TICK_W)) u_unpack (
    .wr_word (cfg_wr_timing),
    .rd_word (cfg_rd_timing),
    .timing  (timing)
  );

  nst_phase_counter #(.CNT_W(TICK_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_ticks (load_ticks),
    .expire     (phase_end)
  );

  nst_cycle_fsm #(.TICK_W(TICK_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .timing     (timing),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_data   (req_data),
    .dev_ready  (dev_ready),
    .dq_in      (nand_dq_in),
    .phase_end  (phase_end),
    .load       (load),
    .load_ticks (load_ticks),
    .accept     (accept),
    .sample_evt (sample_evt),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data),
    .dq_out     (nand_dq_out),
    .dq_oe      (nand_dq_oe),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n)
  );
endmodule

// File: rtl/nst_checker.sv
module nst_checker (
  input logic clk,
  input logic rst_n,
  input logic dev_ready,
  input logic busy,
  input logic done,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic accept
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R3
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R7
  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n)); // R7
  AST_WE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dev_ready)); // R6
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
endmodule

bind nand_strobe_timer nst_checker u_nst_checker (.*);

// File: tb/nand_strobe_timer_bench.sv
`timescale 1ns/1ps
module nand_strobe_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_wr_timing = '0;
  logic [31:0] cfg_rd_timing = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_data = '0;
  logic        dev_ready = 1'b1;
  logic [7:0]  nand_dq_in = '0;
  logic        busy, done, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  rd_data, nand_dq_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int lowcnt = 0;

  nand_strobe_timer u_nand_strobe_timer (.*);

  always #2.5 clk = ~clk;

  // bus model: returns how many cycles read-enable has been low
  always @(negedge clk) begin
    if (!nand_re_n) lowcnt = lowcnt + 1;
    else lowcnt = 0;
    nand_dq_in = 8'(lowcnt);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ef(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // one bus cycle; counts observed at negedges
  task automatic run_op(input bit wr, input logic [7:0] d, input int rdy_low, input int hold_req,
                        output int blen, output int slen, output int sstart, output int oelen,
                        output int other_low, output int dbad, output bit got_done);
    blen = 0; slen = 0; sstart = -1; oelen = 0; other_low = 0; dbad = 0; got_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_data = d;
    @(posedge clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i >= hold_req) req_valid = 1'b0;
      req_data = ~d;
      req_write = ~wr;
      dev_ready = (i >= rdy_low);
      if (busy) blen++;
      if ((wr && !nand_we_n) || (!wr && !nand_re_n)) begin
        if (sstart < 0) sstart = i;
        slen++;
      end
      if ((wr && !nand_re_n) || (!wr && !nand_we_n)) other_low++;
      if (nand_dq_oe) oelen++;
      if (!nand_we_n && nand_dq_out != d) dbad++;
      if (done) begin got_done = 1; break; end
    end
    req_valid = 1'b0;
    dev_ready = 1'b1;
    @(negedge clk);
    chk(!done, "R6 done single pulse", int'(done), 0);
  endtask

  task automatic q64(input logic [63:0] khz, input logic [63:0] ps);
    logic [63:0] prod, q, exp;
    prod = khz * ps;
    q = prod / 64'd1000000000;
    exp = (q * 64'd1000000000 == prod) ? q : q + 1;
    chk(nst_pkg::ticks_from_ps(khz, ps) == exp, "R9 tick rounding",
        int'(nst_pkg::ticks_from_ps(khz, ps)), int'(exp));
  endtask

  initial begin
    int blen, slen, sstart, oelen, olow, dbad, exp_b, hi, rl;
    bit gd;
    logic [7:0] last_rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(!busy && !done && !nand_dq_oe, "R8 reset control", int'({busy, done, nand_dq_oe}), 0);
    chk(nand_we_n && nand_re_n, "R8 reset strobes", int'({nand_we_n, nand_re_n}), 3);
    chk(rd_data == 8'd0, "R8 reset rd_data", int'(rd_data), 0);

    // R1 R2 R4 R7: write sweep
    for (int s = 0; s < 2; s++)
      for (int wl = 0; wl < 4; wl++)
        for (int wc = 0; wc < 4; wc++)
          for (int ex = 0; ex < 3; ex += 2) begin
            cfg_wr_timing = {8'(s), 8'(ex), 8'(wc), 8'(wl)};
            cfg_rd_timing = 32'h0505_0505;
            hi = (ef(wc) > ef(wl)) ? ef(wc) - ef(wl) : 1;
            exp_b = ef(s) + ef(wl) + hi + ef(ex) + 1;
            run_op(1'b1, 8'(8'hA0 + wl * 4 + wc), 0, 0, blen, slen, sstart, oelen, olow, dbad, gd);
            chk(gd, "R6 write done", int'(gd), 1);
            chk(blen == exp_b, "R4 write busy length", blen, exp_b);
            chk(slen == ef(wl), "R2 R4 we_n low length", slen, ef(wl));
            chk(sstart == ef(s), "R1 R4 setup before we_n", sstart, ef(s));
            chk(oelen == ef(s) + ef(wl) + hi, "R4 data drive length", oelen, ef(s) + ef(wl) + hi);
            chk(dbad == 0, "R3 R4 latched write byte", dbad, 0);
            chk(olow == 0, "R7 re_n idle in write", olow, 0);
          end

    // R1 R2 R5 R7: read sweep
    for (int ac = 0; ac < 4; ac++)
      for (int rp = 0; rp < 4; rp++)
        for (int hd = 0; hd < 3; hd += 2)
          for (int rr = 0; rr < 2; rr++) begin
            cfg_wr_timing = {8'd1, 8'd9, 8'd9, 8'd9};
            cfg_rd_timing = {8'(ac), 8'(hd), 8'(rp), 8'(rr)};
            rl = (ef(ac) > ef(rp)) ? ef(ac) : ef(rp);
            exp_b = 1 + rl + ef(hd) + ef(rr) + 1;
            run_op(1'b0, 8'h00, 0, 0, blen, slen, sstart, oelen, olow, dbad, gd);
            chk(gd, "R6 read done", int'(gd), 1);
            chk(blen == exp_b, "R5 read busy length", blen, exp_b);
            chk(slen == rl, "R2 R5 re_n low length", slen, rl);
            chk(sstart == 1, "R1 R5 setup before re_n", sstart, 1);
            chk(int'(rd_data) == rl, "R5 sample at end of low phase", int'(rd_data), rl);
            chk(oelen == 0 && olow == 0, "R7 no drive or we_n in read", oelen + olow, 0);
          end
    last_rd = rd_data;

    // R3: dev_ready low blocks acceptance
    cfg_wr_timing = 32'h0102_0302;
    @(negedge clk);
    dev_ready = 1'b0; req_valid = 1'b1; req_write = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy, "R3 no accept while not ready", int'(busy), 0);
    end
    req_valid = 1'b0; dev_ready = 1'b1;

    // R6: completion waits for dev_ready; base busy = 1+2+1+2+1 = 7
    run_op(1'b1, 8'h5C, 11, 0, blen, slen, sstart, oelen, olow, dbad, gd);
    chk(gd, "R6 done after ready", int'(gd), 1);
    chk(blen == 12, "R6 busy stretched by dev_ready", blen, 12);
    chk(rd_data == last_rd, "R6 write leaves rd_data", int'(rd_data), int'(last_rd));

    // R3: request held during busy is ignored
    run_op(1'b1, 8'h3E, 0, 3, blen, slen, sstart, oelen, olow, dbad, gd);
    chk(blen == 7, "R3 held request ignored", blen, 7);
    chk(dbad == 0, "R3 data change ignored", dbad, 0);
    repeat (2) @(negedge clk);
    chk(!busy, "R3 idle after single cycle", int'(busy), 0);

    // R9 conversion helper
    q64(64'd200000, 64'd20000);
    q64(64'd200000, 64'd20001);
    q64(64'd100000, 64'd0);
    q64(64'd133333, 64'd7500);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule